// File: doc/BRIEF.md
# DMA Source-ID Domain Classifier

This block sorts incoming DMA requests into supervisor domains. An I/O bridge presents each request as a source-identifier type, a 24-bit source ID and a flag that marks the request as belonging to a trusted execution environment. The block compares the request against a table of classification rules. It answers with hit or miss. On a hit it also returns the supervisor-domain ID, the IOMMU instance that must translate the request, and the protection-table mode and root page number stored in the winning rule.

Each rule chooses its own way of matching the source ID. It can require an exact match, match an aligned power-of-two block of IDs, or match a range. The range starts at the ID held by the rule just below it and ends below its own ID. A rule also filters on the trusted-environment flag. Rules are loaded and read back through a plain indexed configuration port. Requests enter on a valid/ready interface and results leave on a second valid/ready interface. When `cpl_valid` is high and `cpl_ready` is low, the completion is held unchanged and `req_ready` drops, so a stalled consumer stops new requests from being accepted. The pipeline is one entry deep, so with `cpl_ready` held high a request can be accepted on every clock.

Top module: `dma_sid_classifier`

## Requirements
- R1: After reset every rule slot reads as zero, `req_ready` is 1, `cpl_valid` is 0, and every request completes as a miss.
- R2: A rule is a 96-bit word with this layout: type in [3:0], match mode in [5:4], TEE filter in [7:6], source ID in [31:8], IOMMU ID in [39:32], domain ID in [47:40], table mode in [51:48] and root page number in [95:52]. Slots 1 to 16 take a write when `cfg_we` is high and read back combinationally on `cfg_rdata`. Index 0 and indices above 16 ignore writes and read as zero.
- R3: A rule can match only a request whose type equals the rule's type, and the type must be 1 (device ID, all 24 bits used) or 2 (stream ID in bits 7:0 and segment in bits 15:8, with bits 23:16 ignored on both sides). Type 0 and every other type never match.
- R4: Match mode 1 matches only when the compared source-ID bits are equal to the rule's ID.
- R5: In match mode 2, the bits of the rule's ID from bit 0 up to and including its lowest 0 bit are don't-care, and the remaining compared bits must be equal.
- R6: In match mode 3, rule k matches IDs that are at least the ID of rule k-1 and strictly below its own ID. Rule 1 uses 0 as its lower bound. The lower bound comes from the rule below whatever that rule's type or mode is.
- R7: A mode-3 rule whose lower bound is greater than or equal to its own ID matches nothing.
- R8: The TEE filter takes these values: 1 admits only requests with `req_tee`=1, 2 admits only requests with `req_tee`=0, 3 admits both, and 0 admits none.
- R9: Match mode 0 never matches.
- R10: When several rules match, the rule with the lowest number decides the result.
- R11: On a hit the completion carries the winning rule's IOMMU ID, domain ID, table mode and root page number. On a miss `cpl_hit` is 0 and all of those fields are 0.
- R12: A request is accepted on a clock edge where both `req_valid` and `req_ready` are high. Its completion shows up with `cpl_valid` high after that edge. `req_ready` is high when `cpl_valid` is low or `cpl_ready` is high. While `cpl_ready` is low the completion stays stable. The result reflects the table as it stood at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the rule slot at `cfg_idx` |
| cfg_idx | input | 5 | Rule number for writes and reads (1..16 are valid) |
| cfg_wdata | input | 96 | Rule word to be written |
| cfg_rdata | output | 96 | Rule word held at `cfg_idx` |
| req_valid | input | 1 | A request is being offered |
| req_ready | output | 1 | The block can accept a request |
| req_type | input | 4 | Source-identifier type of the request |
| req_sid | input | 24 | Source ID of the request |
| req_tee | input | 1 | The request belongs to a trusted environment |
| cpl_valid | output | 1 | A completion is being offered |
| cpl_ready | input | 1 | The consumer takes the completion |
| cpl_hit | output | 1 | Some rule matched |
| cpl_iommu | output | 8 | IOMMU instance ID of the winning rule |
| cpl_dom | output | 8 | Supervisor-domain ID of the winning rule |
| cpl_tmode | output | 4 | Protection-table mode of the winning rule |
| cpl_ppn | output | 44 | Root page number of the winning rule |

## Verification
The hardest case to reach from the ports is a range rule whose lower bound comes from a neighbour that is itself an exact or disabled rule, or whose bound is inverted. That neighbour's ID then changes what the range rule admits without the neighbour ever matching anything. Directed tables put an exact rule with a large ID directly below a range rule, and set up overlapping rules to expose the lowest-number-wins ordering. Random tables then draw their IDs from a small pool, so that ranges, masked blocks and exact rules keep overlapping and bounds are often inverted. Every completion is compared with a model of the rule table kept in the bench.

// File: rtl/sdc_pkg.sv
`timescale 1ns/1ps
package sdc_pkg;
  localparam int SID_W   = 24;
  localparam int IOMMU_W = 8;
  localparam int DOM_W   = 8;
  localparam int TMODE_W = 4;
  localparam int PPN_W   = 44;
  localparam int KIND_W  = 4;

  // identifier kinds
  localparam logic [KIND_W-1:0] KIND_OFF    = 4'd0;
  localparam logic [KIND_W-1:0] KIND_DEV    = 4'd1;
  localparam logic [KIND_W-1:0] KIND_STREAM = 4'd2;

  // match modes
  localparam logic [1:0] MM_OFF   = 2'd0;
  localparam logic [1:0] MM_EXACT = 2'd1;
  localparam logic [1:0] MM_BLOCK = 2'd2;
  localparam logic [1:0] MM_RANGE = 2'd3;

  // trusted-environment filter
  localparam logic [1:0] TF_NONE   = 2'd0;
  localparam logic [1:0] TF_TRUST  = 2'd1;
  localparam logic [1:0] TF_PLAIN  = 2'd2;
  localparam logic [1:0] TF_EITHER = 2'd3;

  // bits 23:16 are ignored for stream-keyed rules
  localparam logic [SID_W-1:0] STREAM_MASK = 24'h00FFFF;

  typedef struct packed {
    logic [PPN_W-1:0]   ppn;
    logic [TMODE_W-1:0] tmode;
    logic [DOM_W-1:0]   dom;
    logic [IOMMU_W-1:0] iommu;
    logic [SID_W-1:0]   sid;
    logic [1:0]         tee;
    logic [1:0]         mmode;
    logic [KIND_W-1:0]  kind;
  } rule_t;

  localparam int RULE_W = $bits(rule_t);
endpackage

// File: rtl/sdc_rule_store.sv
`timescale 1ns/1ps
module sdc_rule_store
  import sdc_pkg::*;
#(
  parameter int NUM_RULES = 16,
  parameter int IDX_W     = $clog2(NUM_RULES + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          idx,
  input  rule_t                     wr_rule,
  output rule_t                     rd_rule,
  output rule_t [NUM_RULES-1:0]     table_o
);
  logic idx_ok;
  assign idx_ok = (idx != '0) && (int'(idx) <= NUM_RULES);

  // slot k holds rule number k+1; number 0 has no storage
  for (genvar k = 0; k < NUM_RULES; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) table_o[k] <= '0;
      else if (wr_en && idx == IDX_W'(k + 1)) table_o[k] <= wr_rule;
    end
  end

  always_comb begin
    rd_rule = '0;
    for (int k = 0; k < NUM_RULES; k++)
      if (idx == IDX_W'(k + 1)) rd_rule = table_o[k];
  end

  a_r2_bad_idx_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !idx_ok) |=> $stable(table_o));

  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx_ok) |=> (rd_rule == $past(wr_rule)) || (idx != $past(idx)));
endmodule

// File: rtl/sdc_rule_match.sv
`timescale 1ns/1ps
module sdc_rule_match
  import sdc_pkg::*;
#(
  parameter int NUM_RULES = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  rule_t [NUM_RULES-1:0] table_i,
  input  logic [KIND_W-1:0]     req_type,
  input  logic [SID_W-1:0]      req_sid,
  input  logic                  req_tee,
  output logic [NUM_RULES-1:0]  hit_vec
);
  for (genvar g = 0; g < NUM_RULES; g++) begin : g_rule
    rule_t            r;
    logic [SID_W-1:0] below_sid, field_mask, care;
    logic [SID_W-1:0] q_id, c_id, lo_id;
    logic             kind_ok, tee_ok, id_ok;

    assign r = table_i[g];
    if (g == 0) begin : g_first
      assign below_sid = '0;
    end else begin : g_next
      assign below_sid = table_i[g-1].sid;
    end

    assign field_mask = (r.kind == KIND_STREAM) ? STREAM_MASK : '1;
    assign q_id  = req_sid & field_mask;
    assign c_id  = r.sid & field_mask;
    assign lo_id = below_sid & field_mask;
    // don't-care bits: trailing ones plus the lowest zero
    assign care  = ~(r.sid ^ (r.sid + SID_W'(1)));

    assign kind_ok = (r.kind == req_type) &&
                     ((r.kind == KIND_DEV) || (r.kind == KIND_STREAM));

    always_comb begin
      case (r.tee)
        TF_TRUST:  tee_ok = req_tee;
        TF_PLAIN:  tee_ok = !req_tee;
        TF_EITHER: tee_ok = 1'b1;
        default:   tee_ok = 1'b0;
      endcase
    end

    always_comb begin
      case (r.mmode)
        MM_EXACT: id_ok = (q_id == c_id);
        MM_BLOCK: id_ok = (((req_sid ^ r.sid) & care & field_mask) == '0);
        MM_RANGE: id_ok = (q_id >= lo_id) && (q_id < c_id);
        default:  id_ok = 1'b0;
      endcase
    end

    assign hit_vec[g] = kind_ok && tee_ok && id_ok;

    a_r3_kind_off: assert property (@(posedge clk) disable iff (!rst_n)
      (r.kind == KIND_OFF) |-> !hit_vec[g]);
    a_r9_mode_off: assert property (@(posedge clk) disable iff (!rst_n)
      (r.mmode == MM_OFF) |-> !hit_vec[g]);
    a_r7_range_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (r.mmode == MM_RANGE && lo_id >= c_id) |-> !hit_vec[g]);
    a_r8_tee_none: assert property (@(posedge clk) disable iff (!rst_n)
      (r.tee == TF_NONE) |-> !hit_vec[g]);
  end
endmodule

// File: rtl/sdc_prio_pick.sv
`timescale 1ns/1ps
module sdc_prio_pick #(
  parameter int NUM_RULES = 16,
  parameter int SEL_W     = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_RULES-1:0] hit_vec,
  output logic                 any_hit,
  output logic [SEL_W-1:0]     sel
);
  logic [NUM_RULES-1:0] grant;

  assign grant   = hit_vec & ~(hit_vec - NUM_RULES'(1));
  assign any_hit = |hit_vec;

  always_comb begin
    sel = '0;
    for (int i = NUM_RULES - 1; i >= 0; i--)
      if (hit_vec[i]) sel = SEL_W'(i);
  end

  a_r10_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  a_r10_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> (hit_vec[sel] && ((hit_vec & ((NUM_RULES'(1) << sel) - NUM_RULES'(1))) == '0)));
endmodule

// File: rtl/dma_sid_classifier.sv
`timescale 1ns/1ps
module dma_sid_classifier
  import sdc_pkg::*;
#(
  parameter int NUM_RULES = 16,
  localparam int IDX_W = $clog2(NUM_RULES + 1),
  localparam int SEL_W = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [RULE_W-1:0]  cfg_wdata,
  output logic [RULE_W-1:0]  cfg_rdata,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [KIND_W-1:0]  req_type,
  input  logic [SID_W-1:0]   req_sid,
  input  logic               req_tee,
  output logic               cpl_valid,
  input  logic               cpl_ready,
  output logic               cpl_hit,
  output logic [IOMMU_W-1:0] cpl_iommu,
  output logic [DOM_W-1:0]   cpl_dom,
  output logic [TMODE_W-1:0] cpl_tmode,
  output logic [PPN_W-1:0]   cpl_ppn
);
  rule_t                 table_w [1];
  rule_t [NUM_RULES-1:0] rules;
  rule_t                 rd_rule, win;
  logic [NUM_RULES-1:0]  hit_vec;
  logic                  any_hit, accept;
  logic [SEL_W-1:0]      sel;

  assign table_w[0] = rule_t'(cfg_wdata);

  sdc_rule_store #(.NUM_RULES(NUM_RULES), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .idx(cfg_idx),
    .wr_rule(table_w[0]), .rd_rule(rd_rule), .table_o(rules)
  );
  assign cfg_rdata = rd_rule;

  sdc_rule_match #(.NUM_RULES(NUM_RULES)) u_match (
    .clk(clk), .rst_n(rst_n), .table_i(rules), .req_type(req_type),
    .req_sid(req_sid), .req_tee(req_tee), .hit_vec(hit_vec)
  );

  sdc_prio_pick #(.NUM_RULES(NUM_RULES), .SEL_W(SEL_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .hit_vec(hit_vec), .any_hit(any_hit), .sel(sel)
  );

  assign win       = rules[sel];
  assign req_ready = !cpl_valid || cpl_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpl_valid <= 1'b0;
      cpl_hit   <= 1'b0;
      cpl_iommu <= '0;
      cpl_dom   <= '0;
      cpl_tmode <= '0;
      cpl_ppn   <= '0;
    end else if (accept) begin
      cpl_valid <= 1'b1;
      cpl_hit   <= any_hit;
      cpl_iommu <= any_hit ? win.iommu : '0;
      cpl_dom   <= any_hit ? win.dom   : '0;
      cpl_tmode <= any_hit ? win.tmode : '0;
      cpl_ppn   <= any_hit ? win.ppn   : '0;
    end else if (cpl_ready) begin
      cpl_valid <= 1'b0;
    end
  end

  a_r12_accept_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> cpl_valid);
  a_r12_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && !cpl_ready) |=> (cpl_valid && $stable({cpl_hit, cpl_iommu, cpl_dom, cpl_tmode, cpl_ppn})));
  a_r12_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && cpl_ready && !req_valid) |=> !cpl_valid);
  a_r11_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && !cpl_hit) |-> ({cpl_iommu, cpl_dom, cpl_tmode, cpl_ppn} == '0));
endmodule

// File: tb/dma_sid_classifier_test.sv
`timescale 1ns/1ps
module dma_sid_classifier_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we = 1'b0;
  logic [4:0]   cfg_idx = '0;
  logic [95:0]  cfg_wdata = '0;
  logic [95:0]  cfg_rdata;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [3:0]   req_type = '0;
  logic [23:0]  req_sid = '0;
  logic         req_tee = 1'b0;
  logic         cpl_valid;
  logic         cpl_ready = 1'b1;
  logic         cpl_hit;
  logic [7:0]   cpl_iommu, cpl_dom;
  logic [3:0]   cpl_tmode;
  logic [43:0]  cpl_ppn;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [95:0] mdl [1:16];

  always #2 clk = ~clk;

  dma_sid_classifier uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_type(req_type), .req_sid(req_sid),
    .req_tee(req_tee), .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
    .cpl_hit(cpl_hit), .cpl_iommu(cpl_iommu), .cpl_dom(cpl_dom),
    .cpl_tmode(cpl_tmode), .cpl_ppn(cpl_ppn)
  );

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [95:0] mk(input logic [3:0] kind, input logic [1:0] mm,
      input logic [1:0] tf, input logic [23:0] sid, input logic [7:0] io,
      input logic [7:0] dm, input logic [3:0] tm, input logic [43:0] pp);
    return {pp, tm, dm, io, sid, tf, mm, kind};
  endfunction

  // rule number that decides the request, 0 for a miss
  function automatic int ref_pick(input logic [3:0] t, input logic [23:0] s, input logic te);
    for (int r = 1; r <= 16; r++) begin
      logic [95:0] w;
      logic [23:0] cid, lo, m;
      int width, n;
      bit ok;
      w = mdl[r];
      cid = w[31:8];
      lo = (r == 1) ? 24'd0 : mdl[r-1][31:8];
      if (w[3:0] != t || !(t == 4'd1 || t == 4'd2)) continue;
      if (w[7:6] == 2'd0 || (w[7:6] == 2'd1 && !te) || (w[7:6] == 2'd2 && te)) continue;
      width = (t == 4'd2) ? 16 : 24;
      m = (t == 4'd2) ? 24'h00FFFF : 24'hFFFFFF;
      ok = 0;
      case (w[5:4])
        2'd1: ok = ((s & m) == (cid & m));
        2'd2: begin
          n = 0;
          while (n < 24 && cid[n]) n++;
          ok = 1;
          for (int b = n + 1; b < width; b++) if (s[b] != cid[b]) ok = 0;
        end
        2'd3: ok = ((s & m) >= (lo & m)) && ((s & m) < (cid & m));
        default: ok = 0;
      endcase
      if (ok) return r;
    end
    return 0;
  endfunction

  task automatic wr(input int idx, input logic [95:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 5'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (idx >= 1 && idx <= 16) mdl[idx] = d;
  endtask

  task automatic clear_all();
    for (int i = 1; i <= 16; i++) wr(i, '0);
  endtask

  task automatic send(input logic [3:0] t, input logic [23:0] s, input logic te,
                      output logic [64:0] got);
    @(negedge clk);
    req_valid = 1'b1; req_type = t; req_sid = s; req_tee = te;
    if (!req_ready) chk(0, "R12 req_ready", 96'(req_ready), 96'd1);
    @(negedge clk);
    req_valid = 1'b0;
    if (!cpl_valid) chk(0, "R12 cpl_valid", 96'(cpl_valid), 96'd1);
    got = {cpl_hit, cpl_iommu, cpl_dom, cpl_tmode, cpl_ppn};
  endtask

  function automatic logic [64:0] expect_for(input int r);
    if (r == 0) return '0;
    return {1'b1, mdl[r][39:32], mdl[r][47:40], mdl[r][51:48], mdl[r][95:52]};
  endfunction

  task automatic probe(input logic [3:0] t, input logic [23:0] s, input logic te,
                       input int exp_rule, input string req);
    logic [64:0] got, exp;
    send(t, s, te, got);
    exp = expect_for(exp_rule);
    chk(got == exp && ref_pick(t, s, te) == exp_rule, req, 96'(got), 96'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [64:0] g1, g2;
    void'($urandom(32'd20240611));
    for (int i = 1; i <= 16; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(req_ready == 1'b1 && cpl_valid == 1'b0, "R1 idle handshake",
        {94'd0, req_ready, cpl_valid}, 96'd2);
    cfg_idx = 5'd7; #1;
    chk(cfg_rdata == '0, "R1 slot empty", cfg_rdata, '0);
    probe(4'd1, 24'h000000, 1'b0, 0, "R1 empty table misses");

    // R2 bad indices ignored, layout read back
    wr(0, mk(4'd1, 2'd1, 2'd3, 24'h000042, 8'h01, 8'h02, 4'h3, 44'h4));
    wr(17, mk(4'd1, 2'd1, 2'd3, 24'h000042, 8'h01, 8'h02, 4'h3, 44'h4));
    cfg_idx = 5'd0; #1;
    chk(cfg_rdata == '0, "R2 index 0 reads zero", cfg_rdata, '0);
    cfg_idx = 5'd17; #1;
    chk(cfg_rdata == '0, "R2 index 17 reads zero", cfg_rdata, '0);
    probe(4'd1, 24'h000042, 1'b0, 0, "R2 index 0 write ignored");

    wr(3, mk(4'd1, 2'd1, 2'd3, 24'h123456, 8'h11, 8'h22, 4'h5, 44'hABCDE12345));
    cfg_idx = 5'd3; #1;
    chk(cfg_rdata == mdl[3], "R2 readback", cfg_rdata, mdl[3]);
    probe(4'd1, 24'h123456, 1'b1, 3, "R4 exact hit R11 fields");
    probe(4'd1, 24'h123457, 1'b0, 0, "R4 exact off by one");
    probe(4'd2, 24'h123456, 1'b0, 0, "R3 type mismatch");

    // R3 stream type ignores upper byte, R8 trusted only
    wr(4, mk(4'd2, 2'd1, 2'd1, 24'h00ABCD, 8'h33, 8'h44, 4'h6, 44'h1));
    probe(4'd2, 24'hFFABCD, 1'b1, 4, "R3 stream upper byte ignored");
    probe(4'd2, 24'hFFABCD, 1'b0, 0, "R8 trusted-only rejects plain");

    // R5 aligned block 0x100..0x10F
    wr(5, mk(4'd1, 2'd2, 2'd3, 24'h000107, 8'h55, 8'h66, 4'h7, 44'h2));
    probe(4'd1, 24'h00010F, 1'b0, 5, "R5 block top");
    probe(4'd1, 24'h000100, 1'b1, 5, "R5 block base");
    probe(4'd1, 24'h000110, 1'b0, 0, "R5 block outside");

    // R6 ranges
    clear_all();
    wr(1, mk(4'd1, 2'd3, 2'd3, 24'h000010, 8'h0A, 8'h0B, 4'h1, 44'h10));
    wr(2, mk(4'd1, 2'd3, 2'd3, 24'h000040, 8'h1A, 8'h1B, 4'h2, 44'h20));
    probe(4'd1, 24'h000000, 1'b0, 1, "R6 first rule from zero");
    probe(4'd1, 24'h00000F, 1'b0, 1, "R6 first rule top");
    probe(4'd1, 24'h000010, 1'b0, 2, "R6 bound from rule below");
    probe(4'd1, 24'h00003F, 1'b1, 2, "R6 range top");
    probe(4'd1, 24'h000040, 1'b0, 0, "R6 top exclusive");

    // R7 inverted bound from an exact rule below
    wr(6, mk(4'd1, 2'd1, 2'd3, 24'h000500, 8'h6A, 8'h6B, 4'h3, 44'h60));
    wr(7, mk(4'd1, 2'd3, 2'd3, 24'h000200, 8'h7A, 8'h7B, 4'h4, 44'h70));
    probe(4'd1, 24'h000150, 1'b0, 0, "R7 inverted range empty");
    probe(4'd1, 24'h000500, 1'b0, 6, "R7 neighbour still exact");

    // R9 mode off
    wr(8, mk(4'd1, 2'd0, 2'd3, 24'h000777, 8'h8A, 8'h8B, 4'h5, 44'h80));
    probe(4'd1, 24'h000777, 1'b0, 0, "R9 mode 0 never matches");

    // R8 filter values
    wr(9, mk(4'd1, 2'd1, 2'd2, 24'h000900, 8'h9A, 8'h9B, 4'h6, 44'h90));
    wr(10, mk(4'd1, 2'd1, 2'd0, 24'h000901, 8'hAA, 8'hAB, 4'h7, 44'hA0));
    probe(4'd1, 24'h000900, 1'b1, 0, "R8 plain-only rejects trusted");
    probe(4'd1, 24'h000900, 1'b0, 9, "R8 plain-only admits plain");
    probe(4'd1, 24'h000901, 1'b1, 0, "R8 filter 0 rejects trusted");
    probe(4'd1, 24'h000901, 1'b0, 0, "R8 filter 0 rejects plain");

    // R10 priority
    wr(11, mk(4'd1, 2'd1, 2'd3, 24'h000A00, 8'hB1, 8'hB2, 4'h8, 44'hB0));
    wr(12, mk(4'd1, 2'd2, 2'd3, 24'h000A0F, 8'hC1, 8'hC2, 4'h9, 44'hC0));
    probe(4'd1, 24'h000A00, 1'b0, 11, "R10 lowest number wins");
    wr(11, '0);
    probe(4'd1, 24'h000A00, 1'b0, 12, "R10 next rule after disable");

    // R12 back-pressure
    cpl_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_type = 4'd1; req_sid = 24'h000A03; req_tee = 1'b0;
    @(negedge clk);
    req_type = 4'd1; req_sid = 24'h000005;
    chk(cpl_valid && !req_ready, "R12 stall blocks intake",
        {94'd0, cpl_valid, req_ready}, 96'd2);
    g1 = {cpl_hit, cpl_iommu, cpl_dom, cpl_tmode, cpl_ppn};
    wr(12, '0);
    repeat (2) @(negedge clk);
    g2 = {cpl_hit, cpl_iommu, cpl_dom, cpl_tmode, cpl_ppn};
    chk(g1 == expect_for(0) ? 0 : (g2 == g1 && g1[64]), "R12 held while stalled", 96'(g2), 96'(g1));
    cpl_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    g2 = {cpl_hit, cpl_iommu, cpl_dom, cpl_tmode, cpl_ppn};
    chk(cpl_valid && g2 == expect_for(ref_pick(4'd1, 24'h000005, 1'b0)),
        "R12 queued request completes", 96'(g2), 96'(expect_for(ref_pick(4'd1, 24'h000005, 1'b0))));
    @(negedge clk);
    chk(!cpl_valid, "R12 drains", 96'(cpl_valid), 96'd0);

    // random tables
    for (int round = 0; round < 10; round++) begin
      for (int i = 1; i <= 16; i++) begin
        logic [3:0] k;
        logic [23:0] sid;
        case ($urandom % 6)
          0: k = 4'd0;
          1, 2: k = 4'd1;
          3, 4: k = 4'd2;
          default: k = 4'd7;
        endcase
        sid = ($urandom % 4 == 0) ? 24'($urandom) : {8'($urandom % 2 ? $urandom : 0), 16'($urandom % 64)};
        wr(i, mk(k, 2'($urandom), 2'($urandom), sid, 8'($urandom), 8'($urandom),
                 4'($urandom), {12'($urandom), 32'($urandom)}));
      end
      for (int n = 0; n < 150; n++) begin
        logic [3:0] t;
        logic [23:0] s;
        logic te;
        logic [64:0] got, exp;
        t = ($urandom % 8 == 0) ? 4'd7 : 4'($urandom % 3);
        s = ($urandom % 4 == 0) ? 24'($urandom) : {8'($urandom % 3 == 0 ? $urandom : 0), 16'($urandom % 64)};
        te = 1'($urandom);
        send(t, s, te, got);
        exp = expect_for(ref_pick(t, s, te));
        chk(got == exp, "R10 R11 random classify", 96'(got), 96'(exp));
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule